// File: doc/BRIEF.md
# Wiper Register Control Core

This block holds the control state behind a 7-bit digitally controlled wiper. It keeps a live position register that drives the wiper code and a stored boot register that stands in for non-volatile memory. A self-timed write cycle with a busy flag models that memory's write time. A control register selects which of the two registers address 0 reaches and holds a soft shutdown bit. Register accesses arrive on a simple byte-wide port. The serial bus front end drives this port and marks the end of each bus transfer with a one-cycle pulse.

After reset the wiper sits at midscale. Once the supply-good input is seen, the block waits a set delay and then copies the boot value into the live register. Until that copy is done the port is held off. A write to the boot register moves the wiper at once. The stored value is committed when the transfer ends. A busy window then follows, and during it further writes are refused. A low shutdown pin or a cleared shutdown bit parks the wiper output at code 0 without changing the registers.

Top module: `wpr_ctrl_core`

## Requirements
- R1: From reset until the boot copy, the wiper code is 40h, `port_ready` is 0, and the control register at address 2 reads 40h.
- R2: The boot copy happens, and `port_ready` rises, exactly PWRUP_CYCLES+1 clock edges after `supply_good` is first sampled high. Accesses made before `port_ready` is 1 have no effect.
- R3: With select bit (address 2, bit 7) at 0, a write to address 0 sets the wiper code to data bits 6..0 on the next edge. Bit 7 of the data is dropped. The boot register, which address 0 reads in this mode, takes the value when `xfer_end` pulses.
- R4: With the select bit at 1, address 0 reads and writes the live position register only, and the boot register is left unchanged.
- R5: An `xfer_end` pulse after a boot-register write sets the busy flag (address 2, bit 5) for exactly NVW_CYCLES cycles. An `xfer_end` pulse with no such write pending leaves the flag at 0.
- R6: While the busy flag is 1, writes to address 0 and address 2 are discarded.
- R7: `shut_off` is 1 when `shdn_pin_n` is 0 or the shutdown bit (address 2, bit 6, reset value 1) is 0. While it is 1, `wiper_code` is 0. When it clears, the wiper returns to the held position.
- R8: Registers are readable and writable during shutdown.
- R9: Writes to addresses 1 and 3 are discarded, and reads from them return 00h. Control-register bits 4..0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_good | input | 1 | Supply high enough for boot-value recall |
| shdn_pin_n | input | 1 | Shutdown pin, active low |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 2 | Register address |
| acc_wdata | input | 8 | Write data |
| xfer_end | input | 1 | One-cycle pulse at the end of a bus transfer |
| acc_rdata | output | 8 | Read data for acc_addr (combinational) |
| port_ready | output | 1 | Boot copy done, accesses accepted |
| wiper_code | output | 7 | Wiper tap code, 00h nearest ground |
| shut_off | output | 1 | Shutdown in effect |

## Verification
Address 0 is written in both select modes. The boot value is read back before and after the transfer-end pulse. This shows whether a write reached the live register, the stored register, or both. Data with bit 7 set shows that only seven bits are kept. Writes issued inside the busy window, and before the port is ready, separate refused accesses from accepted ones. The cycle count of both windows is checked against its parameter. Shutdown is driven from the pin and from the bit in turn, with a write between entry and exit, to show that the parked output and the held position stay distinct.

// File: rtl/wpr_pkg.sv
// Shared definitions for the wiper register control core.
// Assumes a 2-bit register address and an 8-bit control register.
package wpr_pkg;
    typedef enum logic [1:0] {
        ADDR_POS  = 2'd0,
        ADDR_RSV1 = 2'd1,
        ADDR_CTL  = 2'd2,
        ADDR_RSV3 = 2'd3
    } reg_addr_e;

    localparam int CTL_SEL_BIT  = 7;
    localparam int CTL_SHUT_BIT = 6;
    localparam int CTL_BUSY_BIT = 5;

    typedef enum logic [1:0] {
        PU_WAIT  = 2'd0,
        PU_DELAY = 2'd1,
        PU_DONE  = 2'd2
    } pu_state_e;
endpackage

// File: rtl/wpr_pwrup_seq.sv
// Power-up sequencer: waits for supply_good, counts DELAY_CYCLES, then
// issues a one-cycle recall pulse and raises port_ready for good.
// Assumes DELAY_CYCLES >= 1 and that supply_good is not re-armed.
module wpr_pwrup_seq #(
    parameter int DELAY_CYCLES = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_good,
    output logic recall_pulse,
    output logic port_ready
);
    import wpr_pkg::*;

    localparam int CNT_W = $clog2(DELAY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DELAY_CYCLES - 1);

    pu_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;

    // Recall fires on the last delay cycle.
    assign recall_pulse = (state_q == PU_DELAY) && (cnt_q == CNT_LAST);
    assign port_ready   = (state_q == PU_DONE);

    // Sequence state and delay counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PU_WAIT;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                PU_WAIT: if (supply_good) begin
                    state_q <= PU_DELAY;
                    cnt_q   <= '0;
                end
                PU_DELAY: if (cnt_q == CNT_LAST) begin
                    state_q <= PU_DONE;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                default: state_q <= PU_DONE;
            endcase
        end
    end
endmodule

// File: rtl/wpr_nv_cycle.sv
// Self-timed store cycle: a start pulse holds busy high for exactly CYCLES
// clock cycles. Assumes start only arrives while busy is low.
module wpr_nv_cycle #(
    parameter int CYCLES = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] left_q;

    assign busy = (left_q != '0);

    // Remaining-cycle counter, loaded on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= CNT_W'(CYCLES);
        end else if (busy) begin
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/wpr_shut_gate.sv
// Combines the shutdown pin with the shutdown bit and parks the wiper code
// at zero while shut down; the held position is passed through otherwise.
module wpr_shut_gate #(
    parameter int CODE_W = 7
) (
    input  logic              pin_n,
    input  logic              bit_run,
    input  logic [CODE_W-1:0] pos,
    output logic              shut,
    output logic [CODE_W-1:0] code
);
    // Either source alone enters shutdown.
    always_comb begin
        shut = !(pin_n && bit_run);
        code = shut ? '0 : pos;
    end
endmodule

// File: rtl/wpr_ctrl_core.sv
// Wiper register control core: live position register, stored boot register
// with a self-timed commit, control register with select/shutdown/busy bits.
// Assumes one access per acc_valid cycle and xfer_end as a one-cycle pulse
// not coincident with a write. Reset models power-on; the boot register then
// takes BOOT_INIT, standing in for the retained stored value.
module wpr_ctrl_core #(
    parameter int          CODE_W       = 7,
    parameter int          DATA_W       = 8,
    parameter int          PWRUP_CYCLES = 300000,
    parameter int          NVW_CYCLES   = 2000000,
    parameter logic [6:0]  BOOT_INIT    = 7'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_good,
    input  logic              shdn_pin_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              xfer_end,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              port_ready,
    output logic [CODE_W-1:0] wiper_code,
    output logic              shut_off
);
    import wpr_pkg::*;

    localparam logic [CODE_W-1:0] MIDSCALE = CODE_W'(1) << (CODE_W - 1);
    localparam int                PAD_W    = DATA_W - CODE_W;

    logic [CODE_W-1:0] pos_q;
    logic [CODE_W-1:0] boot_q;
    logic [CODE_W-1:0] stage_q;
    logic              stage_pend;
    logic              sel_live_q;
    logic              run_bit_q;
    logic              busy;
    logic              recall;
    logic              wr_ok;
    logic              nv_start;

    wpr_pwrup_seq #(.DELAY_CYCLES(PWRUP_CYCLES)) i_pwrup (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_good  (supply_good),
        .recall_pulse (recall),
        .port_ready   (port_ready)
    );

    wpr_nv_cycle #(.CYCLES(NVW_CYCLES)) i_nvc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (nv_start),
        .busy  (busy)
    );

    wpr_shut_gate #(.CODE_W(CODE_W)) i_shut (
        .pin_n   (shdn_pin_n),
        .bit_run (run_bit_q),
        .pos     (pos_q),
        .shut    (shut_off),
        .code    (wiper_code)
    );

    // Accepted write: port open and no store cycle running.
    assign wr_ok    = acc_valid && acc_write && port_ready && !busy;
    assign nv_start = xfer_end && stage_pend;

    // Register state updates: recall, commit, and accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q      <= MIDSCALE;
            boot_q     <= BOOT_INIT[CODE_W-1:0];
            stage_q    <= '0;
            stage_pend <= 1'b0;
            sel_live_q <= 1'b0;
            run_bit_q  <= 1'b1;
        end else begin
            if (recall) begin
                pos_q <= boot_q;
            end
            if (nv_start) begin
                boot_q     <= stage_q;
                stage_pend <= 1'b0;
            end
            if (wr_ok) begin
                case (reg_addr_e'(acc_addr))
                    ADDR_POS: begin
                        pos_q <= acc_wdata[CODE_W-1:0];
                        if (!sel_live_q) begin
                            stage_q    <= acc_wdata[CODE_W-1:0];
                            stage_pend <= 1'b1;
                        end
                    end
                    ADDR_CTL: begin
                        sel_live_q <= acc_wdata[CTL_SEL_BIT];
                        run_bit_q  <= acc_wdata[CTL_SHUT_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read mux: address 0 follows the select bit; reserved addresses read 0.
    always_comb begin
        acc_rdata = '0;
        case (reg_addr_e'(acc_addr))
            ADDR_POS: acc_rdata = {{PAD_W{1'b0}}, (sel_live_q ? pos_q : boot_q)};
            ADDR_CTL: begin
                acc_rdata[CTL_SEL_BIT]  = sel_live_q;
                acc_rdata[CTL_SHUT_BIT] = run_bit_q;
                acc_rdata[CTL_BUSY_BIT] = busy;
            end
            default: acc_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wpr_ctrl_core_chk.sv
// Checker for wpr_ctrl_core, bound to every instance of it.
// Assumes the synchronous active-low reset of the core.
module wpr_ctrl_core_chk #(
    parameter int CODE_W = 7,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              port_ready,
    input logic              busy,
    input logic              stage_pend,
    input logic              xfer_end,
    input logic [CODE_W-1:0] pos_q,
    input logic              shdn_pin_n,
    input logic              shut_off,
    input logic [CODE_W-1:0] wiper_code,
    input logic [1:0]        acc_addr,
    input logic [DATA_W-1:0] acc_rdata
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    a_r1_mid_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !port_ready |-> (pos_q == MID));

    a_r2_ready_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        port_ready |=> port_ready);

    a_r5_busy_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end && stage_pend) |=> busy);

    a_r6_pos_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(pos_q));

    a_r7_pin_parks_code: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_pin_n |-> (shut_off && wiper_code == '0));

    a_r9_rsv_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr == 2'd1 || acc_addr == 2'd3) |-> (acc_rdata == '0));
endmodule

bind wpr_ctrl_core wpr_ctrl_core_chk #(.CODE_W(CODE_W), .DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_ready (port_ready),
    .busy       (busy),
    .stage_pend (stage_pend),
    .xfer_end   (xfer_end),
    .pos_q      (pos_q),
    .shdn_pin_n (shdn_pin_n),
    .shut_off   (shut_off),
    .wiper_code (wiper_code),
    .acc_addr   (acc_addr),
    .acc_rdata  (acc_rdata)
);

// File: tb/test_wpr_ctrl_core.sv
// Directed bench for wpr_ctrl_core; one task per scenario.
module test_wpr_ctrl_core;
    localparam int         CLK_PERIOD = 10;
    localparam int         P_UP       = 8;
    localparam int         P_NV       = 20;
    localparam logic [6:0] BOOT       = 7'h25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_good = 1'b0;
    logic       shdn_pin_n = 1'b1;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic [1:0] acc_addr = 2'd0;
    logic [7:0] acc_wdata = 8'h00;
    logic       xfer_end = 1'b0;
    logic [7:0] acc_rdata;
    logic       port_ready;
    logic [6:0] wiper_code;
    logic       shut_off;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wpr_ctrl_core #(
        .PWRUP_CYCLES (P_UP),
        .NVW_CYCLES   (P_NV),
        .BOOT_INIT    (BOOT)
    ) i_wpr_ctrl_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_good (supply_good),
        .shdn_pin_n  (shdn_pin_n),
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .acc_addr    (acc_addr),
        .acc_wdata   (acc_wdata),
        .xfer_end    (xfer_end),
        .acc_rdata   (acc_rdata),
        .port_ready  (port_ready),
        .wiper_code  (wiper_code),
        .shut_off    (shut_off)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        acc_addr = a;
        #1 d = acc_rdata;
    endtask

    task automatic end_xfer();
        @(negedge clk);
        xfer_end = 1'b1;
        @(negedge clk);
        xfer_end = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] c;
        for (int i = 0; i < 200; i++) begin
            rd(2'd2, c);
            if (c[5] == 1'b0) break;
        end
    endtask

    task automatic t_reset_state();
        logic [7:0] c;
        rd(2'd2, c);
        check("R1 ctl reset", c, 8'h40);
        check("R1 mid code", wiper_code, 7'h40);
        check("R1 not ready", port_ready, 0);
    endtask

    task automatic t_powerup();
        logic [7:0] c;
        wr(2'd2, 8'h80);          // before ready: must be ignored (R2)
        wr(2'd0, 8'h11);
        @(negedge clk);
        supply_good = 1'b1;
        repeat (P_UP) @(negedge clk);
        check("R2 ready low at P", port_ready, 0);
        check("R1 still mid at P", wiper_code, 7'h40);
        @(negedge clk);
        check("R2 ready at P+1", port_ready, 1);
        check("R2 boot copied", wiper_code, BOOT);
        rd(2'd2, c);
        check("R2 early write ignored", c, 8'h40);
    endtask

    task automatic t_nv_write();
        logic [7:0] c;
        int hi;
        wr(2'd0, 8'hB3);
        check("R3 wiper follows 7 bits", wiper_code, 7'h33);
        rd(2'd0, c);
        check("R3 boot held until end", c, BOOT);
        end_xfer();
        hi = 0;
        for (int i = 0; i < 200; i++) begin
            #1;
            acc_addr = 2'd2;
            #1;
            if (acc_rdata[5] == 1'b0) break;
            hi++;
            @(negedge clk);
        end
        check("R5 busy length", hi, P_NV);
        rd(2'd0, c);
        check("R3 boot committed", c, 8'h33);
        end_xfer();
        rd(2'd2, c);
        check("R5 no pending no busy", c, 8'h40);
    endtask

    task automatic t_busy_lockout();
        logic [7:0] c;
        wr(2'd0, 8'h10);
        end_xfer();
        wr(2'd0, 8'h7F);
        wr(2'd2, 8'h80);
        check("R6 pos write refused", wiper_code, 7'h10);
        rd(2'd2, c);
        check("R6 ctl write refused", c, 8'h60);
        wait_idle();
        rd(2'd2, c);
        check("R6 ctl after busy", c, 8'h40);
        rd(2'd0, c);
        check("R6 boot kept", c, 8'h10);
    endtask

    task automatic t_volatile();
        logic [7:0] c;
        wr(2'd2, 8'hC0);
        wr(2'd0, 8'h5A);
        check("R4 live write", wiper_code, 7'h5A);
        rd(2'd0, c);
        check("R4 live read", c, 8'h5A);
        end_xfer();
        rd(2'd2, c);
        check("R4 no store cycle", c, 8'hC0);
        wr(2'd2, 8'h40);
        rd(2'd0, c);
        check("R4 boot untouched", c, 8'h10);
        check("R4 code kept", wiper_code, 7'h5A);
    endtask

    task automatic t_shutdown();
        logic [7:0] c;
        wr(2'd2, 8'hC0);
        @(negedge clk);
        shdn_pin_n = 1'b0;
        #1;
        check("R7 pin shut", shut_off, 1);
        check("R7 pin parks code", wiper_code, 0);
        wr(2'd0, 8'h11);
        check("R8 parked during write", wiper_code, 0);
        rd(2'd0, c);
        check("R8 write in shutdown", c, 8'h11);
        @(negedge clk);
        shdn_pin_n = 1'b1;
        #1;
        check("R7 pin release", shut_off, 0);
        check("R7 code returns", wiper_code, 7'h11);
        wr(2'd2, 8'h80);
        check("R7 bit shut", shut_off, 1);
        check("R7 bit parks code", wiper_code, 0);
        wr(2'd2, 8'hC0);
        check("R7 bit release code", wiper_code, 7'h11);
    endtask

    task automatic t_reserved();
        logic [7:0] c;
        wr(2'd1, 8'hFF);
        wr(2'd3, 8'h3F);
        rd(2'd1, c);
        check("R9 addr1 reads 0", c, 0);
        rd(2'd3, c);
        check("R9 addr3 reads 0", c, 0);
        rd(2'd2, c);
        check("R9 ctl unchanged", c, 8'hC0);
        check("R9 code unchanged", wiper_code, 7'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_powerup();
        t_nv_write();
        t_busy_lockout();
        t_volatile();
        t_shutdown();
        t_reserved();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end
endmodule